// File: doc/BRIEF.md
# Windowed Bidirectional Shift Register Bank

A bank of single-bit storage cells. Part of the bank works as a shift register. Its extent is set at run time by a head index and a length. Each rising edge seen on `pulse` moves the contents of that window one place. With `dir` low, the shift runs toward higher indices and `din` enters at the head. With `dir` high, it runs toward lower indices and `din` enters at the last window cell. Cells outside the window keep their values through shifts and window clears.

A half-size mode limits the usable bank to its lower half. A window that does not fit the usable bank is reported on `win_err` and is never acted on. Single cells can be forced high or low through a set port and a reset port. A synchronous clear zeroes the window. The whole bank is visible in parallel on `cells_o`. During power-on reset the bank is cleared, unless `keep_on_boot` asks for the contents to be retained.

Top module: `winshift_bank`

## Requirements
- R1: The usable size is 64 cells, or 32 when `half_mode` is 1. `win_err` is high, combinationally, when `len` is 0 or `head + len` exceeds the usable size. While `win_err` is high, no shift and no window clear take place.
- R2: A shift happens only in a cycle where `pulse` is 1 and was 0 in the previous cycle, and it moves the window by exactly one place. A pulse held high gives no further shifts. A pulse that is already high when reset is released gives no shift.
- R3: Forward shift (`dir` = 0): each window cell above the head takes the previous value of the cell one index below it, and the head cell takes `din`.
- R4: Reverse shift (`dir` = 1): each window cell below the tail (`head + len - 1`) takes the previous value of the cell one index above it, and the tail cell takes `din`.
- R5: `clr` = 1 with a valid window zeroes every window cell. `clr` has top priority: in that cycle, neither a shift nor a set or reset request takes effect.
- R6: When there is no clear and no shift, `set_en` forces cell `set_idx` to 1 and `rst_en` forces cell `rst_idx` to 0. If both name the same cell, the reset wins. An index at or above the usable size is ignored.
- R7: Cells outside the window never change on a shift or a window clear.
- R8: While `rst_n` is 0 at a clock edge, all cells are cleared when `keep_on_boot` is 0, and keep their contents when it is 1.
- R9: `cells_o[i]` shows cell i. Every change becomes visible after the clock edge that applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| keep_on_boot | input | 1 | 1 keeps cell contents through reset |
| half_mode | input | 1 | 1 limits the usable bank to 32 cells |
| head | input | 6 | Index of the first window cell |
| len | input | 7 | Number of window cells |
| dir | input | 1 | 0 forward, 1 reverse |
| pulse | input | 1 | Shift request, acted on at its rising edge |
| din | input | 1 | Bit shifted into the window |
| clr | input | 1 | Clear the window |
| set_en | input | 1 | Force one cell to 1 |
| set_idx | input | 6 | Cell forced to 1 |
| rst_en | input | 1 | Force one cell to 0 |
| rst_idx | input | 6 | Cell forced to 0 |
| cells_o | output | 64 | Parallel view of all cells |
| win_err | output | 1 | Window does not fit the usable bank |

## Verification
Every cell is visible on `cells_o`, so a wrong window bound, neighbour choice or edge history appears as a wrong bit one cycle after the offending edge. The bench compares the whole 64-bit vector every cycle against a model, and any disturbed cell outside the window is caught at once. A stale edge history shows as a missing shift, or an extra one, in the cycle after the pulse rises. A wrong size limit shows the same cycle as a mismatch on `win_err`.

// File: rtl/winshift_bank.sv
module winshift_bank #(
  parameter int CELLS = 64,
  parameter int HALF  = CELLS / 2,
  parameter int IW    = $clog2(CELLS),
  parameter int LW    = $clog2(CELLS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             keep_on_boot,
  input  logic             half_mode,
  input  logic [IW-1:0]    head,
  input  logic [LW-1:0]    len,
  input  logic             dir,
  input  logic             pulse,
  input  logic             din,
  input  logic             clr,
  input  logic             set_en,
  input  logic [IW-1:0]    set_idx,
  input  logic             rst_en,
  input  logic [IW-1:0]    rst_idx,
  output logic [CELLS-1:0] cells_o,
  output logic             win_err
);
  localparam int SW = LW + 1;

  logic [CELLS-1:0] cells, nxt, up, dn;
  logic             pulse_q;
  logic [SW-1:0]    size, wend;
  logic             rise, do_shift, do_clr;

  assign size     = half_mode ? SW'(HALF) : SW'(CELLS);
  assign wend     = SW'(head) + SW'(len);
  assign win_err  = (len == '0) || (wend > size);
  assign rise     = pulse & ~pulse_q;
  assign do_clr   = clr & ~win_err;
  assign do_shift = rise & ~clr & ~win_err;
  assign up       = {cells[CELLS-2:0], 1'b0};
  assign dn       = {1'b0, cells[CELLS-1:1]};
  assign cells_o  = cells;

  always_comb begin
    nxt = cells;
    for (int i = 0; i < CELLS; i++) begin
      if (SW'(i) >= SW'(head) && SW'(i) < wend) begin
        if (do_clr)
          nxt[i] = 1'b0;
        else if (do_shift && !dir)
          nxt[i] = (SW'(i) == SW'(head)) ? din : up[i];
        else if (do_shift && dir)
          nxt[i] = (SW'(i) == wend - SW'(1)) ? din : dn[i];
      end
      if (!clr && !do_shift && SW'(i) < size) begin
        if (set_en && set_idx == IW'(i)) nxt[i] = 1'b1;
        if (rst_en && rst_idx == IW'(i)) nxt[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b1;
      if (!keep_on_boot) cells <= '0;
    end else begin
      pulse_q <= pulse;
      cells   <= nxt;
    end
  end
endmodule

module winshift_bank_chk #(
  parameter int CELLS = 64,
  parameter int HALF  = CELLS / 2,
  parameter int IW    = $clog2(CELLS),
  parameter int LW    = $clog2(CELLS) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             keep_on_boot,
  input logic             half_mode,
  input logic [IW-1:0]    head,
  input logic [LW-1:0]    len,
  input logic             dir,
  input logic             pulse,
  input logic             din,
  input logic             clr,
  input logic             set_en,
  input logic [IW-1:0]    set_idx,
  input logic             rst_en,
  input logic [IW-1:0]    rst_idx,
  input logic [CELLS-1:0] cells_o,
  input logic             win_err
);
  a_r2_held_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && $past(pulse) && $past(rst_n) && !clr && !set_en && !rst_en) |=> $stable(cells_o));

  a_r1_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_err && !set_en && !rst_en) |=> $stable(cells_o));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !win_err) |=> (cells_o[$past(head)] == 1'b0));

  a_r3_fwd_head: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !$past(pulse) && $past(rst_n) && !clr && !win_err && !dir)
      |=> (cells_o[$past(head)] == $past(din)));

  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !clr && !pulse && !(rst_en && rst_idx == set_idx)
       && (int'(set_idx) < (half_mode ? HALF : CELLS)))
      |=> cells_o[$past(set_idx)]);
endmodule

bind winshift_bank winshift_bank_chk #(.CELLS(CELLS), .HALF(HALF), .IW(IW), .LW(LW)) u_chk (.*);

// File: tb/winshift_bank_tb.sv
`timescale 1ns/1ps
module winshift_bank_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, keep_on_boot = 1'b0, half_mode = 1'b0;
  logic [5:0] head = '0, set_idx = '0, rst_idx = '0;
  logic [6:0] len = 7'd1;
  logic dir = 1'b0, pulse = 1'b0, din = 1'b0, clr = 1'b0, set_en = 1'b0, rst_en = 1'b0;
  logic [63:0] cells_o;
  logic win_err;

  int checks = 0, errors = 0;
  bit [63:0] m;
  bit mq;

  always #2 clk = ~clk;

  winshift_bank dut_i (.*);

  function automatic bit model_err();
    int sz = half_mode ? 32 : 64;
    return (len == 0) || (int'(head) + int'(len) > sz);
  endfunction

  function automatic bit [63:0] model_next();
    bit [63:0] n = m;
    int h = head, t = int'(head) + int'(len) - 1, sz = half_mode ? 32 : 64;
    bit sh = pulse && !mq && !clr && !model_err();
    if (!rst_n) return keep_on_boot ? m : 64'd0;
    if (clr) begin
      if (!model_err()) for (int i = h; i <= t; i++) n[i] = 1'b0;
    end else if (sh) begin
      if (!dir) begin
        for (int i = t; i > h; i--) n[i] = m[i-1];
        n[h] = din;
      end else begin
        for (int i = h; i < t; i++) n[i] = m[i+1];
        n[t] = din;
      end
    end else begin
      if (set_en && set_idx < sz) n[set_idx] = 1'b1;
      if (rst_en && rst_idx < sz) n[rst_idx] = 1'b0;
    end
    return n;
  endfunction

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cells_o=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    bit [63:0] e;
    #1;
    checks++;
    if (win_err !== model_err()) begin
      errors++;
      $display("FAIL R1 (%s): win_err=%b expected %b", tag, win_err, model_err());
    end
    e = model_next();
    mq = !rst_n ? 1'b1 : pulse;
    @(posedge clk);
    @(negedge clk);
    m = e;
    check64(tag, cells_o, m);
  endtask

  task automatic idle();
    pulse = 0; clr = 0; set_en = 0; rst_en = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd17));
    m = '0; mq = 1'b1;
    @(negedge clk);
    cyc("R8 reset clears");
    cyc("R8 reset clears");
    rst_n = 1;
    cyc("R9 idle after reset");

    head = 0; len = 4; dir = 0; din = 1;
    pulse = 1; cyc("R3 forward shift in");
    cyc("R2 held pulse no shift");
    pulse = 0; din = 0; cyc("R2 pulse low");
    pulse = 1; cyc("R3 forward second shift");
    pulse = 0; set_en = 1; set_idx = 40; cyc("R6 set outside window");
    set_en = 0; head = 1; len = 3; dir = 1; din = 1; pulse = 1; cyc("R4 reverse shift tail");
    pulse = 0; cyc("R7 idle");
    clr = 1; head = 0; len = 2; cyc("R5 window clear");
    clr = 1; set_en = 1; set_idx = 10; cyc("R5 clear beats set");
    idle(); set_en = 1; rst_en = 1; set_idx = 12; rst_idx = 12; cyc("R6 reset wins");
    idle(); half_mode = 1; set_en = 1; set_idx = 45; cyc("R6 index beyond half size ignored");
    idle(); head = 30; len = 3; pulse = 1; din = 1; cyc("R1 invalid window no shift");
    idle(); clr = 1; head = 60; len = 10; half_mode = 0; cyc("R1 invalid window no clear");
    idle(); head = 0; len = 0; cyc("R1 zero length");
    idle(); head = 63; len = 1; half_mode = 0; dir = 0; din = 1; pulse = 1; cyc("R3 top single cell");
    pulse = 1; keep_on_boot = 1; rst_n = 0; cyc("R8 keep through reset");
    rst_n = 1; cyc("R2 pulse high at release no shift");
    keep_on_boot = 0; idle();

    for (int k = 0; k < 4000; k++) begin
      half_mode = ($urandom % 8) == 0;
      head = $urandom % 64;
      len = 1 + $urandom % 64;
      if (($urandom % 4) != 0) len = 1 + $urandom % (64 - head);
      dir = $urandom % 2;
      din = $urandom % 2;
      pulse = $urandom % 2;
      clr = ($urandom % 16) == 0;
      set_en = ($urandom % 4) == 0;
      rst_en = ($urandom % 4) == 0;
      set_idx = $urandom % 64;
      rst_idx = ($urandom % 4 == 0) ? set_idx : 6'($urandom % 64);
      keep_on_boot = $urandom % 2;
      rst_n = ($urandom % 200) != 0;
      if (clr) cyc("R5 random clear");
      else if (!dir) cyc("R3 random forward/R7");
      else cyc("R4 random reverse/R6");
    end
    rst_n = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule